// File: doc/BRIEF.md
# Gated Pixel Clock Capture and Frame Position Tracker

This block receives pixels from a source whose pixel clock is gated: it ticks once per pixel, then stops. It moves them into a faster local clock that runs all the time. In the source domain a single register flips on every rising edge of the source pixel clock. That toggle, the pixel data and both sync lines then cross into the local domain through a multi-register synchronizer. Each change seen on the synchronized toggle becomes exactly one local pixel strobe. Because of this, a burst of source edges followed by a long pause neither loses nor repeats a pixel.

Behind the synchronizer, column and row counters place each pixel inside a frame (160 by 144 by default). Every pixel is emitted with its column, its row and a write address for a line buffer that holds four lines and wraps. A downstream consumer runs two lines behind the input. A flush level goes high once the last pixel of the frame has been delivered, so that consumer can drain its final lines. The next vertical sync drops the flush level.

Top module: `pixel_capture`

## Requirements
- R1: Each rising edge of `src_pclk` produces exactly one `pix_valid` pulse, one local cycle wide, provided successive source edges are at least two local cycles apart; `pix_valid` stays low while the source clock is stopped.
- R2: With the default two synchronizer stages, `pix_valid` is high in the third local cycle after the local edge that follows the source edge. The bench raises the source edge mid-cycle and sees the pulse after the third local rising edge.
- R3: `pix_data` carries the 2-bit value that was held on `src_data` with the source edge that produced the pulse.
- R4: `pix_col` counts 0,1,2,… on successive pulses. After column 159 it returns to 0, and the row advances by one.
- R5: After the pixel at row 143, column 159, the next pixel is at row 0, column 0.
- R6: `pix_addr` equals (row mod 4) × 160 + column for the emitted pixel.
- R7: `frame_flush` rises in the same cycle as the pulse for row 143, column 159. It stays high until a vertical sync clears it.
- R8: While `src_hsync` is high (after synchronization), the column counter is held at 0 and the row counter keeps its value. The next pixel therefore comes out at column 0 of the same row.
- R9: While `src_vsync` is high (after synchronization), both counters are held at 0 and `frame_flush` is cleared. The clear is visible three local cycles after the local edge that follows the vsync rise.
- R10: After reset, `pix_valid`, `pix_data`, `pix_col`, `pix_row`, `pix_addr` and `frame_flush` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| rst_n | input | 1 | Asynchronous active-low reset, also clears the source-domain toggle |
| src_pclk | input | 1 | Gated source pixel clock |
| src_hsync | input | 1 | Source horizontal sync, active high |
| src_vsync | input | 1 | Source vertical sync, active high |
| src_data | input | 2 | Source pixel value |
| pix_valid | output | 1 | One-cycle strobe per received pixel |
| pix_data | output | 2 | Pixel value for the strobe |
| pix_col | output | 8 | Column of the pixel |
| pix_row | output | 8 | Row of the pixel |
| pix_addr | output | 10 | Line-buffer write address, four lines deep |
| frame_flush | output | 1 | High from the last pixel of a frame until vsync |

## Verification
Some properties are checked by assertions on every cycle: strobes are one cycle wide, positions stay inside the frame, the flush level rises only together with the final pixel, and the syncs clear the counters. What only the bench scenarios can show is that every source edge yields exactly one strobe with the exact latency and the right data. The bench also shows the column and row sequence, including the wraps. Those scenarios mix bursts at the minimum edge spacing, long clock stops, a short line ended by hsync, a mid-frame vsync, and a full frame whose last pixel raises flush.

// File: rtl/pcap_pkg.sv
package pcap_pkg;
   localparam int DEF_COLS   = 160;
   localparam int DEF_ROWS   = 144;
   localparam int DEF_BANKS  = 4;
   localparam int DEF_STAGES = 2;
   localparam int DEF_DW     = 2;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pcap_src_toggle.sv
module pcap_src_toggle (
   input  logic src_clk,
   input  logic rst_n,
   output logic tog
);
   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) tog <= 1'b0;
      else        tog <= ~tog;
   end
endmodule

// File: rtl/pcap_sync.sv
module pcap_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   initial begin
      if (STAGES < 2) $error("pcap_sync: STAGES must be at least 2");
      if (W < 1)      $error("pcap_sync: W must be positive");
   end

   logic [STAGES-1:0][W-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pcap_position.sv
module pcap_position #(
   parameter int COLS  = 160,
   parameter int ROWS  = 144,
   parameter int BANKS = 4,
   parameter int DW    = 2,
   localparam int CW   = $clog2(COLS),
   localparam int RW   = $clog2(ROWS),
   localparam int BB   = $clog2(BANKS),
   localparam int AW   = $clog2(BANKS * COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          hs,
   input  logic          vs,
   input  logic [DW-1:0] din,
   output logic          valid_q,
   output logic [DW-1:0] data_q,
   output logic [CW-1:0] col_q,
   output logic [RW-1:0] row_q,
   output logic [AW-1:0] addr_q,
   output logic          flush_q
);
   initial begin
      if (COLS < 2)  $error("pcap_position: COLS must be at least 2");
      if (ROWS < 2)  $error("pcap_position: ROWS must be at least 2");
      if (BANKS < 2) $error("pcap_position: BANKS must be at least 2");
   end

   logic [CW-1:0] col_cnt;
   logic [RW-1:0] row_cnt;
   logic [BB-1:0] bank;
   logic          col_last, row_last;

   assign col_last = (col_cnt == CW'(COLS - 1));
   assign row_last = (row_cnt == RW'(ROWS - 1));

   generate
      if (pcap_pkg::is_pow2(BANKS)) begin : g_bank_mask
         assign bank = row_cnt[BB-1:0];
      end else begin : g_bank_mod
         assign bank = BB'(row_cnt % RW'(BANKS));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         col_q   <= '0;
         row_q   <= '0;
         addr_q  <= '0;
         flush_q <= 1'b0;
         col_cnt <= '0;
         row_cnt <= '0;
      end else begin
         valid_q <= step;
         if (step) begin
            data_q <= din;
            col_q  <= col_cnt;
            row_q  <= row_cnt;
            addr_q <= AW'(bank) * AW'(COLS) + AW'(col_cnt);
         end
         if (vs) begin
            col_cnt <= '0;
            row_cnt <= '0;
            flush_q <= 1'b0;
         end else if (hs) begin
            col_cnt <= '0;
         end else if (step) begin
            if (col_last) begin
               col_cnt <= '0;
               row_cnt <= row_last ? '0 : row_cnt + 1'b1;
               if (row_last) flush_q <= 1'b1;
            end else begin
               col_cnt <= col_cnt + 1'b1;
            end
         end
      end
   end

   p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |=> !valid_q);

   p_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q |-> (col_q < CW'(COLS)) && (row_q < RW'(ROWS)));

   p_flush_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flush_q) |-> valid_q && col_q == CW'(COLS - 1) && row_q == RW'(ROWS - 1));

   p_hs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && !vs) |=> col_cnt == '0 && row_cnt == $past(row_cnt));

   p_vs_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vs |=> col_cnt == '0 && row_cnt == '0 && !flush_q);
endmodule

// File: rtl/pixel_capture.sv
module pixel_capture #(
   parameter int COLS   = pcap_pkg::DEF_COLS,
   parameter int ROWS   = pcap_pkg::DEF_ROWS,
   parameter int BANKS  = pcap_pkg::DEF_BANKS,
   parameter int STAGES = pcap_pkg::DEF_STAGES,
   parameter int DW     = pcap_pkg::DEF_DW,
   localparam int CW    = $clog2(COLS),
   localparam int RW    = $clog2(ROWS),
   localparam int AW    = $clog2(BANKS * COLS),
   localparam int SW    = DW + 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          src_pclk,
   input  logic          src_hsync,
   input  logic          src_vsync,
   input  logic [DW-1:0] src_data,
   output logic          pix_valid,
   output logic [DW-1:0] pix_data,
   output logic [CW-1:0] pix_col,
   output logic [RW-1:0] pix_row,
   output logic [AW-1:0] pix_addr,
   output logic          frame_flush
);
   logic          tog_src;
   logic [SW-1:0] sync_in, sync_out;
   logic          tog_s, hs_s, vs_s, tog_prev, step;
   logic [DW-1:0] data_s;

   pcap_src_toggle u_tog (
      .src_clk (src_pclk),
      .rst_n   (rst_n),
      .tog     (tog_src)
   );

   assign sync_in = {tog_src, src_hsync, src_vsync, src_data};

   pcap_sync #(.W(SW), .STAGES(STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sync_in),
      .q     (sync_out)
   );

   assign {tog_s, hs_s, vs_s, data_s} = sync_out;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tog_prev <= 1'b0;
      else        tog_prev <= tog_s;
   end

   assign step = tog_s ^ tog_prev;

   pcap_position #(.COLS(COLS), .ROWS(ROWS), .BANKS(BANKS), .DW(DW)) u_pos (
      .clk     (clk),
      .rst_n   (rst_n),
      .step    (step),
      .hs      (hs_s),
      .vs      (vs_s),
      .din     (data_s),
      .valid_q (pix_valid),
      .data_q  (pix_data),
      .col_q   (pix_col),
      .row_q   (pix_row),
      .addr_q  (pix_addr),
      .flush_q (frame_flush)
   );
endmodule

// File: tb/pixel_capture_tb.sv
module pixel_capture_tb;
   localparam int COLS = 160;
   localparam int ROWS = 144;
   localparam int LAT  = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       src_pclk = 1'b0;
   logic       src_hsync = 1'b0;
   logic       src_vsync = 1'b0;
   logic [1:0] src_data = 2'b00;
   logic       pix_valid;
   logic [1:0] pix_data;
   logic [7:0] pix_col;
   logic [7:0] pix_row;
   logic [9:0] pix_addr;
   logic       frame_flush;

   pixel_capture u_dut (
      .clk(clk), .rst_n(rst_n), .src_pclk(src_pclk), .src_hsync(src_hsync),
      .src_vsync(src_vsync), .src_data(src_data), .pix_valid(pix_valid),
      .pix_data(pix_data), .pix_col(pix_col), .pix_row(pix_row),
      .pix_addr(pix_addr), .frame_flush(frame_flush)
   );

   always #4 clk = ~clk;

   typedef struct {
      int         c;
      int         r;
      int         t;
      bit         last;
      logic [1:0] d;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   int   mcol = 0, mrow = 0;
   bit   exp_flush = 1'b0;
   int   vs_clr_cyc = -1;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, cyc);
      end
   endtask

   // per-cycle reference comparison
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (cyc == vs_clr_cyc) exp_flush = 1'b0;
         if (pix_valid) begin
            if (q.size() == 0) begin
               chk(1'b0, "R1", "unexpected pix_valid", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(cyc - e.t == LAT, "R2", "latency", cyc - e.t, LAT);
               chk(pix_data == e.d, "R3", "pix_data", int'(pix_data), int'(e.d));
               chk(int'(pix_col) == e.c, "R4", "pix_col", int'(pix_col), e.c);
               chk(int'(pix_row) == e.r, "R5", "pix_row", int'(pix_row), e.r);
               chk(int'(pix_addr) == (e.r % 4) * COLS + e.c, "R6", "pix_addr",
                   int'(pix_addr), (e.r % 4) * COLS + e.c);
               if (e.last) exp_flush = 1'b1;
            end
         end else if (q.size() != 0 && cyc - q[0].t > LAT) begin
            chk(1'b0, "R1", "missing pix_valid", 0, 1);
            void'(q.pop_front());
         end
         chk(frame_flush == exp_flush, "R7", "frame_flush", int'(frame_flush), int'(exp_flush));
      end
   end

   task automatic send_pix(input logic [1:0] d, input int gap);
      exp_t e;
      @(negedge clk);
      src_data = d;
      src_pclk = 1'b1;
      e.c = mcol; e.r = mrow; e.t = cyc; e.d = d;
      e.last = (mcol == COLS - 1) && (mrow == ROWS - 1);
      q.push_back(e);
      if (mcol == COLS - 1) begin
         mcol = 0;
         mrow = (mrow == ROWS - 1) ? 0 : mrow + 1;
      end else begin
         mcol++;
      end
      @(negedge clk);
      src_pclk = 1'b0;
      repeat (gap) @(negedge clk);
   endtask

   task automatic hsync_pulse();
      repeat (5) @(negedge clk);
      src_hsync = 1'b1;
      mcol = 0;
      repeat (2) @(negedge clk);
      src_hsync = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic vsync_pulse();
      repeat (5) @(negedge clk);
      src_vsync = 1'b1;
      vs_clr_cyc = cyc + LAT;
      mcol = 0;
      mrow = 0;
      repeat (2) @(negedge clk);
      src_vsync = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 200000);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10: reset state
      chk(pix_valid == 1'b0, "R10", "pix_valid", int'(pix_valid), 0);
      chk(pix_data == 2'b00, "R10", "pix_data", int'(pix_data), 0);
      chk(pix_col == 8'd0, "R10", "pix_col", int'(pix_col), 0);
      chk(pix_row == 8'd0, "R10", "pix_row", int'(pix_row), 0);
      chk(pix_addr == 10'd0, "R10", "pix_addr", int'(pix_addr), 0);
      chk(frame_flush == 1'b0, "R10", "frame_flush", int'(frame_flush), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1/R3: bursts at minimum spacing, varied gaps, long clock stop
      send_pix(2'd1, 0);
      send_pix(2'd2, 0);
      send_pix(2'd3, 1);
      send_pix(2'd0, 3);
      repeat (60) @(negedge clk);
      send_pix(2'd3, 7);
      send_pix(2'd2, 2);

      // R8: short line ended by hsync
      hsync_pulse();
      send_pix(2'd1, 2);
      send_pix(2'd2, 2);

      // R9: mid-frame vsync
      vsync_pulse();
      send_pix(2'd3, 2);

      // R4/R5/R6/R7: full frame from origin
      vsync_pulse();
      for (int r = 0; r < ROWS; r++) begin
         for (int c = 0; c < COLS; c++) send_pix(2'((r * 3 + c) & 3), 1);
         hsync_pulse();
      end
      // wrap to row 0 column 0 after the last pixel, flush still high
      send_pix(2'd2, 2);
      repeat (10) @(negedge clk);
      // R9: vsync drops flush
      vsync_pulse();
      repeat (10) @(negedge clk);
      chk(frame_flush == 1'b0, "R9", "flush after vsync", int'(frame_flush), 0);
      chk(q.size() == 0, "R1", "pending pixels", q.size(), 0);
      finish_run();
   end
endmodule